// File: doc/BRIEF.md
# Programmable Third-Order Decimating Low-Pass Filter

This block turns the one-bit stream of a delta-sigma modulator into wide signed samples. A free-running divider produces a sample strobe once every `OSC_DIV` master-clock cycles, and the modulator bit is taken on each strobe. The samples pass through a cascade of integrators and, at the decimated rate, a cascade of differentiators. Together they form a third-order moving-sum filter built only from adders, subtractors and registers.

An 11-bit rate code sets the decimation ratio to four times the code. One word therefore appears every `4 * code * OSC_DIV` master clocks, and this output rate is also the frequency of the filter's first notch. Each new word is marked by a data-ready pulse one cycle wide. Code values below the floor are raised to the floor. A code change takes effect only at the next output boundary, and a short settling window then hides the words that mix the old and new ratios.

Top module: `sinc3_decim`

## Requirements
- R1: While the synchronous reset is high, on every clock edge `dout` returns to 0, `dready` returns to 0, and all integrator, comb, divider and counter state is cleared.
- R2: The modulator input is sampled on the `OSC_DIV`-th clock edge after reset is released, and on every `OSC_DIV`-th edge after that.
- R3: A modulator bit of 1 enters the first integrator as +1, and a bit of 0 enters as −1. A steady stream of ones settles to +R³, and a steady stream of zeros settles to −R³, where R = 4 × effective code.
- R4: An output boundary occurs once every R samples. The data-ready pulses that follow boundaries are spaced exactly `R * OSC_DIV` clocks apart.
- R5: Suppose the input repeats with a period that divides R. Once the filter has settled, every word equals R² times the sum of the ±1 values over any R consecutive samples. For a 4-sample repeating pattern with k ones, this is R³·(k−2)/2.
- R6: Integrators and combs wrap modulo 2^`ACC_W`. The output is exact whenever the true result fits in `ACC_W` signed bits, even after the integrators have wrapped.
- R7: A rate code below `MIN_CODE` (10 by default) acts as `MIN_CODE`. Writing such a code while `MIN_CODE` is already in effect changes neither the timing nor the values.
- R8: The rate code is sampled while reset is high and again at each output boundary. A change made in the middle of a block leaves the length of that block unchanged.
- R9: After reset, the first three boundaries produce no word. The first `dready` pulse comes `4 * R * OSC_DIV + 1` clocks after reset is released.
- R10: When a boundary picks up a different effective code, the word for that boundary is still emitted. The next three boundaries are suppressed, so the following pulse comes `4 * R_new * OSC_DIV` clocks later.
- R11: `dready` is high for exactly one clock per word, and `dout` changes only in the cycle in which `dready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| mod_bit | input | 1 | One-bit modulator stream |
| rate_code | input | CODE_W | Decimation code; ratio is four times the code |
| dout | output | ACC_W | Filtered two's-complement word |
| dready | output | 1 | One-cycle strobe marking a new `dout` |

## Verification
The bench builds the block with `OSC_DIV` = 2 and `ACC_W` = 24, keeping the 11-bit code and the floor of 10. With a 2-cycle strobe, blocks of 40 to 200 samples take only hundreds of clocks each. This makes it practical to sweep all sixteen 4-sample input patterns and to check the settling windows after reset and after code changes. The 24-bit datapath forces the third integrator to wrap many times within a 200-sample block, while R³ = 8,000,000 still fits, so the modulo arithmetic is exercised at its limit.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;
  // Decimation ratio is the rate code shifted left by this amount (x4).
  localparam int unsigned RATE_SHIFT   = 2;
  // Default lowest usable rate code.
  localparam int unsigned CODE_FLOOR   = 10;
  // Default filter order.
  localparam int unsigned FILTER_ORDER = 3;

  // Clamp a rate code to the floor value.
  function automatic logic [15:0] clamp_code(input logic [15:0] raw, input logic [15:0] floor_v);
    return (raw < floor_v) ? floor_v : raw;
  endfunction
endpackage

// File: rtl/sinc3_strobe_div.sv
module sinc3_strobe_div #(
  parameter int unsigned DIV = 128
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_pass
      assign tick = 1'b1;
    end else begin : g_count
      localparam int unsigned CW = $clog2(DIV);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          cnt_q <= '0;
        end else if (cnt_q == CW'(DIV - 1)) begin
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
      assign tick = (cnt_q == CW'(DIV - 1));
    end
  endgenerate
endmodule

// File: rtl/sinc3_integrators.sv
module sinc3_integrators #(
  parameter int unsigned ORDER = 3,
  parameter int unsigned ACC_W = 40
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             bit_in,
  output logic [ACC_W-1:0] acc_out
);
  logic [ACC_W-1:0] acc_q [ORDER];
  logic [ACC_W-1:0] step;

  // +1 for a one, -1 (all ones) for a zero
  assign step = bit_in ? ACC_W'(1) : {ACC_W{1'b1}};

  generate
    for (genvar k = 0; k < ORDER; k++) begin : g_stage
      if (k == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) acc_q[k] <= '0;
          else if (en) acc_q[k] <= acc_q[k] + step;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) acc_q[k] <= '0;
          else if (en) acc_q[k] <= acc_q[k] + acc_q[k-1];
        end
      end
    end
  endgenerate

  assign acc_out = acc_q[ORDER-1];
endmodule

// File: rtl/sinc3_rate_ctl.sv
module sinc3_rate_ctl #(
  parameter int unsigned CODE_W     = 11,
  parameter int unsigned MIN_CODE   = 10,
  parameter int unsigned RATE_SHIFT = 2,
  parameter int unsigned SETTLE     = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [CODE_W-1:0] code_in,
  output logic              cap_o,
  output logic              emit_o
);
  localparam int unsigned CNT_W = CODE_W + RATE_SHIFT;
  localparam int unsigned SET_W = $clog2(SETTLE + 1);

  logic [CODE_W-1:0] eff_code;
  logic [CODE_W-1:0] act_code_q;
  logic [CNT_W-1:0]  smp_cnt_q;
  logic [CNT_W-1:0]  blk_last;
  logic [SET_W-1:0]  settle_q;
  logic              at_end;
  logic              settled;

  assign eff_code = (code_in < CODE_W'(MIN_CODE)) ? CODE_W'(MIN_CODE) : code_in;
  assign blk_last = (CNT_W'(act_code_q) << RATE_SHIFT) - 1'b1;
  assign at_end   = tick && (smp_cnt_q == blk_last);
  assign settled  = (settle_q == SET_W'(SETTLE));

  always_ff @(posedge clk) begin
    if (rst) begin
      act_code_q <= eff_code;
      smp_cnt_q  <= '0;
      settle_q   <= '0;
      cap_o      <= 1'b0;
      emit_o     <= 1'b0;
    end else begin
      cap_o  <= at_end;
      emit_o <= at_end && settled;
      if (at_end) begin
        smp_cnt_q  <= '0;
        act_code_q <= eff_code;
        if (eff_code != act_code_q) begin
          settle_q <= '0;
        end else if (!settled) begin
          settle_q <= settle_q + 1'b1;
        end
      end else if (tick) begin
        smp_cnt_q <= smp_cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sinc3_combs.sv
module sinc3_combs #(
  parameter int unsigned ORDER = 3,
  parameter int unsigned ACC_W = 40
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap,
  input  logic             emit,
  input  logic [ACC_W-1:0] din,
  output logic [ACC_W-1:0] dout,
  output logic             dvalid
);
  logic [ACC_W-1:0] diff [ORDER+1];
  logic [ACC_W-1:0] dly_q [ORDER];

  assign diff[0] = din;

  generate
    for (genvar k = 0; k < ORDER; k++) begin : g_comb
      assign diff[k+1] = diff[k] - dly_q[k];
      always_ff @(posedge clk) begin
        if (rst) dly_q[k] <= '0;
        else if (cap) dly_q[k] <= diff[k];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      dout   <= '0;
      dvalid <= 1'b0;
    end else begin
      dvalid <= cap && emit;
      if (cap && emit) dout <= diff[ORDER];
    end
  end
endmodule

// File: rtl/sinc3_decim.sv
module sinc3_decim
  import sinc3_pkg::*;
#(
  parameter int unsigned OSC_DIV  = 128,
  parameter int unsigned CODE_W   = 11,
  parameter int unsigned ACC_W    = 40,
  parameter int unsigned MIN_CODE = CODE_FLOOR,
  parameter int unsigned ORDER    = FILTER_ORDER
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mod_bit,
  input  logic [CODE_W-1:0] rate_code,
  output logic [ACC_W-1:0]  dout,
  output logic              dready
);
  logic             tick_w;
  logic             cap_w;
  logic             emit_w;
  logic [ACC_W-1:0] integ_w;

  sinc3_strobe_div #(.DIV(OSC_DIV)) div_i (
    .clk (clk),
    .rst (rst),
    .tick(tick_w)
  );

  sinc3_integrators #(.ORDER(ORDER), .ACC_W(ACC_W)) integ_i (
    .clk    (clk),
    .rst    (rst),
    .en     (tick_w),
    .bit_in (mod_bit),
    .acc_out(integ_w)
  );

  sinc3_rate_ctl #(
    .CODE_W    (CODE_W),
    .MIN_CODE  (MIN_CODE),
    .RATE_SHIFT(RATE_SHIFT),
    .SETTLE    (ORDER)
  ) rate_i (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick_w),
    .code_in(rate_code),
    .cap_o  (cap_w),
    .emit_o (emit_w)
  );

  sinc3_combs #(.ORDER(ORDER), .ACC_W(ACC_W)) comb_i (
    .clk   (clk),
    .rst   (rst),
    .cap   (cap_w),
    .emit  (emit_w),
    .din   (integ_w),
    .dout  (dout),
    .dvalid(dready)
  );
endmodule

// File: rtl/sinc3_decim_chk.sv
module sinc3_decim_chk #(
  parameter int unsigned OSC_DIV = 128,
  parameter int unsigned ACC_W   = 40
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             dready,
  input logic [ACC_W-1:0] dout
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (dout == '0 && !dready));

  // R11
  dready_single_chk: assert property (@(posedge clk) disable iff (rst) dready |=> !dready);

  // R11
  dout_hold_chk: assert property (@(posedge clk) disable iff (rst) !$stable(dout) |-> dready);

  // R2
  tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    (OSC_DIV > 1 && tick) |=> !tick);

  // R4
  dready_align_chk: assert property (@(posedge clk) disable iff (rst) dready |-> $past(tick, 2));
endmodule

bind sinc3_decim sinc3_decim_chk #(.OSC_DIV(OSC_DIV), .ACC_W(ACC_W)) chk_i (
  .clk   (clk),
  .rst   (rst),
  .tick  (tick_w),
  .dready(dready),
  .dout  (dout)
);

// File: tb/sinc3_decim_tb_top.sv
module sinc3_decim_tb_top;
  localparam int D  = 2;
  localparam int AW = 24;
  localparam int CW = 11;

  logic          clk = 1'b0;
  logic          rst;
  logic          mod_bit;
  logic [CW-1:0] rate_code;
  logic [AW-1:0] dout;
  logic          dready;
  logic [3:0]    pat;
  int unsigned   ecnt;
  int            n_run = 0;
  int            n_fail = 0;
  bit            done = 1'b0;

  always #4 clk = ~clk;

  sinc3_decim #(.OSC_DIV(D), .CODE_W(CW), .ACC_W(AW)) dut_i (
    .clk(clk), .rst(rst), .mod_bit(mod_bit), .rate_code(rate_code),
    .dout(dout), .dready(dready)
  );

  // edges since reset release; sample n is taken at edge (n+1)*D
  always @(posedge clk) begin
    if (rst) ecnt <= 0;
    else ecnt <= ecnt + 1;
  end

  always @(negedge clk) mod_bit <= pat[(ecnt / D) % 4];

  task automatic chk(string tag, longint act, longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic get_pulse(output int t, output longint v);
    do @(negedge clk); while (!dready);
    t = int'(ecnt);
    v = longint'($signed(dout));
  endtask

  function automatic longint cube(longint r);
    return r * r * r;
  endfunction

  function automatic longint pat_val(longint r, logic [3:0] p);
    return cube(r) * (longint'($countones(p)) - 2) / 2;
  endfunction

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int t, tprev;
    longint v, vhold;
    rst = 1'b1; rate_code = CW'(10); pat = 4'hF; mod_bit = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 dready in reset", dready, 0);
    chk("R1 dout in reset", dout, 0);
    rst = 1'b0;

    // R9 / R2: first word after reset, R = 40
    get_pulse(t, v);
    chk("R9 first pulse time", t, 4 * 40 * D + 1);
    chk("R3 all ones settles to +R^3", v, cube(40));
    tprev = t;
    get_pulse(t, v);
    chk("R4 pulse spacing code 10", t - tprev, 40 * D);
    tprev = t; vhold = v;
    @(negedge clk);
    chk("R11 dready one cycle", dready, 0);
    chk("R11 dout held", longint'($signed(dout)), vhold);

    // R5: sweep of every 4-sample pattern at R = 40
    for (int p = 0; p < 16; p++) begin
      pat = 4'(p);
      for (int k = 0; k < 5; k++) begin
        get_pulse(t, v);
        if (k == 4) begin
          chk($sformatf("R5 pattern %0h value", p), v, pat_val(40, 4'(p)));
          chk($sformatf("R4 pattern %0h spacing", p), t - tprev, 40 * D);
        end
        tprev = t;
      end
    end

    // R7: code below floor behaves as 10, no resettling
    rate_code = CW'(3);
    get_pulse(t, v);
    chk("R7 clamp spacing 1", t - tprev, 40 * D);
    tprev = t;
    get_pulse(t, v);
    chk("R7 clamp spacing 2", t - tprev, 40 * D);
    chk("R7 clamp value", v, cube(40));
    tprev = t;

    // R8 / R10: change to 13 right after a pulse
    rate_code = CW'(13);
    get_pulse(t, v);
    chk("R8 current block keeps old length", t - tprev, 40 * D);
    chk("R10 boundary word emitted", v, cube(40));
    tprev = t;
    get_pulse(t, v);
    chk("R10 three words suppressed", t - tprev, 4 * 52 * D);
    chk("R5 value after code change", v, cube(52));
    tprev = t;
    get_pulse(t, v);
    chk("R4 spacing code 13", t - tprev, 52 * D);
    tprev = t;
    pat = 4'b0111;
    for (int k = 0; k < 5; k++) begin
      get_pulse(t, v);
      tprev = t;
    end
    chk("R5 pattern 7 at R 52", v, pat_val(52, 4'b0111));

    // R6: R = 200 wraps the 24-bit integrators; R^3 still fits
    rate_code = CW'(50); pat = 4'hF;
    get_pulse(t, v);
    chk("R8 spacing before switch", t - tprev, 52 * D);
    tprev = t;
    get_pulse(t, v);
    chk("R10 suppression at R 200", t - tprev, 4 * 200 * D);
    chk("R6 wrapped positive full scale", v, cube(200));
    tprev = t;
    pat = 4'h0;
    for (int k = 0; k < 5; k++) begin
      get_pulse(t, v);
      tprev = t;
    end
    chk("R6 R3 wrapped negative full scale", v, -cube(200));

    done = 1'b1;
    summary();
    $finish;
  end
endmodule